// File: doc/BRIEF.md
# Addressed Serial Display-Data Receiver

This block sits between a host controller and a four-phase multiplexed LCD drive block. The host sends data over a three-wire synchronous link made of a chip enable, a serial clock and a serial data line. Every transfer opens with an 8-bit device address, shifted while chip enable is low. A 48-bit data frame follows while chip enable is high. A frame carries one quarter of a 136-bit display image, and a frame for quarter 0 also carries the control settings. The block latches the frame into its registers on the falling edge of chip enable, and only if the address matched, the frame had the right length and the link timing was clean.

All three link inputs, and the active-low inhibit input, pass through two-flop synchronizers into the system clock domain. Edges are found there. Data is sampled on rising serial-clock edges, so the serial clock may rest either low or high between transfers. The drive block receives the stored image, a 4-bit port-select code, a half-bias select, a segment blank bit, a power-save bit and a force-off flag. The force-off flag holds the panel dark while inhibit is low. This matters after reset, when the image carries no meaning yet.

Top module: `lcd_serial_rx`

## Requirements
- R1: A frame is committed only when the 8 address bits shifted while chip enable was low equal 0x46, sent LSB first. With any other address the image and control outputs stay unchanged.
- R2: The address phase must contain exactly 8 rising serial-clock edges. With 7, 9 or more edges the following frame is rejected, even when the last 8 bits read 0x46.
- R3: Frame bits are shifted LSB first on rising serial-clock edges. Frame bits 0..35 are display data. Frame bits 44..47 are the direction field, and bit 44+q set selects quarter q. Frame bit i then lands in image bit 36q+i, where image bit 0 is the first display dot.
- R4: A frame with any bit count other than 48 between the rise and the fall of chip enable is discarded.
- R5: A frame is discarded when its direction field is not exactly one-hot, or when its reserved bit 43 is 1.
- R6: A quarter-0 frame loads the control outputs as follows: bits 36..39 go to port_sel (bit 36 is the LSB), bit 40 to bias_half, bit 41 to seg_blank and bit 42 to pwr_save. Frames for quarters 1..3 leave the control outputs unchanged, whatever their bits 36..42 hold.
- R7: Outputs change only after chip enable falls. While chip enable stays high after a complete frame, the outputs hold their old values.
- R8: Transfers are received the same way whether the serial clock rests low or high between transfers.
- R9: A frame is discarded if, while chip enable is high, a serial-clock high or low phase lasts fewer than MIN_CYC system cycles, or the data changes fewer than MIN_CYC cycles before or after a rising serial-clock edge.
- R10: After reset the image and control outputs are all zero and force_off is 1. force_off follows the inverse of the synchronized inhibit_n. Frames are still accepted while force_off is 1.
- R11: A committed frame writes only its own quarter. The other quarters keep their contents. Quarter 3 holds image bits 108..135, and frame bits 28..35 of a quarter-3 frame are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_ce | input | 1 | Link chip enable (low: address phase, high: frame phase) |
| ser_clk | input | 1 | Link serial clock, sampled on rising edges |
| ser_din | input | 1 | Link serial data |
| inhibit_n | input | 1 | Active-low display inhibit |
| disp_image | output | 136 | Latched display image |
| port_sel | output | 4 | Latched port-select code |
| bias_half | output | 1 | 1: half-bias drive, 0: third-bias drive |
| seg_blank | output | 1 | 1: segments blanked |
| pwr_save | output | 1 | 1: power-save mode |
| force_off | output | 1 | 1: drive block must force all outputs off |

## Verification
Assertions check on every cycle that the image changes only in the cycle after a commit strobe. They also check that the control register moves only on a quarter-0 commit, that the quarter select of every commit is one-hot, and that a commit follows only a full-length, address-matched frame with no timing violation. force_off tracking inhibit is checked the same way. Only the bench scenarios can show the bit-level mapping of frames into the image. The same holds for rejection of wrong addresses, of wrong address or frame lengths and of too-short clock pulses. Reception with the serial clock resting high is likewise shown only by the scenarios, since these depend on whole transfer sequences and not on one cycle.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;
  localparam int ADDR_BITS = 8;
  localparam int CTRL_BITS = 8;   // 4 port select, bias, blank, power save, reserved
  localparam int PSEL_BITS = 4;
  localparam int BIAS_OFS  = 4;
  localparam int BLANK_OFS = 5;
  localparam int SAVE_OFS  = 6;
  localparam int RSV_OFS   = 7;

  typedef struct packed {
    logic [PSEL_BITS-1:0] port_sel;
    logic                 bias_half;
    logic                 blank;
    logic                 pwr_save;
  } ctrl_t;
endpackage

// File: rtl/lcdrx_sync.sv
module lcdrx_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [1:0] arm_cnt;
  logic       armed;

  // edges are qualified once the delay line holds real samples
  always_ff @(posedge clk) begin
    if (rst)                  arm_cnt <= '0;
    else if (arm_cnt != 2'd3) arm_cnt <= arm_cnt + 2'd1;
  end
  assign armed = (arm_cnt == 2'd3);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign lvl[i]  = sync_q;
    assign rise[i] = armed & sync_q & ~prev_q;
    assign fall[i] = armed & ~sync_q & prev_q;
  end
endmodule

// File: rtl/lcdrx_guard.sv
module lcdrx_guard #(
  parameter int MIN_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_lvl,
  input  logic ce_rise,
  input  logic sclk_rise,
  input  logic sclk_fall,
  input  logic din_chg,
  output logic viol
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_CYC);
  localparam logic [CW-1:0] LIM = CW'(MIN_CYC - 1);

  logic [CW-1:0] since_edge, since_rise, since_din;
  logic          bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_edge <= SAT;
      since_rise <= SAT;
      since_din  <= SAT;
    end else begin
      since_edge <= (sclk_rise | sclk_fall) ? '0 : (since_edge == SAT ? SAT : since_edge + 1'b1);
      since_rise <= sclk_rise ? '0 : (since_rise == SAT ? SAT : since_rise + 1'b1);
      since_din  <= din_chg   ? '0 : (since_din  == SAT ? SAT : since_din  + 1'b1);
    end
  end

  // pulse width, setup before a rising edge, hold after it
  assign bad = ((sclk_rise | sclk_fall) && since_edge < LIM)
             || (sclk_rise && since_din < LIM)
             || (din_chg && since_rise < LIM);

  always_ff @(posedge clk) begin
    if (rst)                viol <= 1'b0;
    else if (ce_rise)       viol <= 1'b0;
    else if (ce_lvl && bad) viol <= 1'b1;
  end
endmodule

// File: rtl/lcdrx_shifter.sv
module lcdrx_shifter
  import lcdrx_pkg::*;
#(
  parameter logic [ADDR_BITS-1:0] DEV_ADDR = 8'h46,
  parameter int QBITS = 36,
  parameter int NQ    = 4,
  localparam int FRAME_BITS = QBITS + CTRL_BITS + NQ,
  localparam int DATA_W     = QBITS + CTRL_BITS - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_lvl,
  input  logic              ce_rise,
  input  logic              ce_fall,
  input  logic              sclk_rise,
  input  logic              din_lvl,
  input  logic              viol,
  output logic              commit_v,
  output logic [NQ-1:0]     commit_q,
  output logic [DATA_W-1:0] commit_data
);
  localparam int BCW = $clog2(FRAME_BITS + 2);
  localparam logic [BCW-1:0] BSAT  = BCW'(FRAME_BITS + 1);
  localparam logic [BCW-1:0] BFULL = BCW'(FRAME_BITS);
  localparam int ACW = $clog2(ADDR_BITS + 2);
  localparam logic [ACW-1:0] ASAT  = ACW'(ADDR_BITS + 1);
  localparam logic [ACW-1:0] AFULL = ACW'(ADDR_BITS);

  logic [FRAME_BITS-1:0] sr;
  logic [BCW-1:0]        bcnt;
  logic [ADDR_BITS-1:0]  areg;
  logic [ACW-1:0]        acnt;
  logic                  addr_ok;
  logic [NQ-1:0]         dir;
  logic                  dir_ok, rsv_bit, accept;

  assign dir     = sr[FRAME_BITS-1 -: NQ];
  assign rsv_bit = sr[QBITS + RSV_OFS];
  assign dir_ok  = (dir != '0) && ((dir & (dir - 1'b1)) == '0);
  assign accept  = addr_ok && (bcnt == BFULL) && !viol && dir_ok && !rsv_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr          <= '0;
      bcnt        <= '0;
      areg        <= '0;
      acnt        <= '0;
      addr_ok     <= 1'b0;
      commit_v    <= 1'b0;
      commit_q    <= '0;
      commit_data <= '0;
    end else begin
      commit_v <= 1'b0;
      if (ce_rise) begin
        addr_ok <= (acnt == AFULL) && (areg == DEV_ADDR);
        bcnt    <= '0;
      end else if (ce_fall) begin
        commit_v    <= accept;
        commit_q    <= dir;
        commit_data <= sr[DATA_W-1:0];
        addr_ok     <= 1'b0;
        acnt        <= '0;
      end else if (sclk_rise) begin
        if (ce_lvl) begin
          sr   <= {din_lvl, sr[FRAME_BITS-1:1]};
          bcnt <= (bcnt == BSAT) ? BSAT : bcnt + 1'b1;
        end else begin
          areg <= {din_lvl, areg[ADDR_BITS-1:1]};
          acnt <= (acnt == ASAT) ? ASAT : acnt + 1'b1;
        end
      end
    end
  end

  assert_addr_gate_R1: assert property (@(posedge clk) disable iff (rst)
    (ce_fall && !addr_ok) |=> !commit_v);
  assert_frame_len_R4: assert property (@(posedge clk) disable iff (rst)
    commit_v |-> (bcnt == BFULL));
  assert_timing_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (ce_fall && viol) |=> !commit_v);
endmodule

// File: rtl/lcdrx_store.sv
module lcdrx_store
  import lcdrx_pkg::*;
#(
  parameter int IMG_BITS = 136,
  parameter int QBITS    = 36,
  parameter int NQ       = 4,
  localparam int DATA_W  = QBITS + CTRL_BITS - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                commit_v,
  input  logic [NQ-1:0]       commit_q,
  input  logic [DATA_W-1:0]   commit_data,
  output logic [IMG_BITS-1:0] img_o,
  output ctrl_t               ctrl_o
);
  for (genvar q = 0; q < NQ; q++) begin : g_quarter
    localparam int LO = q * QBITS;
    localparam int W  = (q == NQ - 1) ? IMG_BITS - LO : QBITS;
    logic [W-1:0] qreg;
    always_ff @(posedge clk) begin
      if (rst)                          qreg <= '0;
      else if (commit_v && commit_q[q]) qreg <= commit_data[W-1:0];
    end
    assign img_o[LO +: W] = qreg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
    end else if (commit_v && commit_q[0]) begin
      ctrl_o.port_sel  <= commit_data[QBITS +: PSEL_BITS];
      ctrl_o.bias_half <= commit_data[QBITS + BIAS_OFS];
      ctrl_o.blank     <= commit_data[QBITS + BLANK_OFS];
      ctrl_o.pwr_save  <= commit_data[QBITS + SAVE_OFS];
    end
  end

  assert_img_after_commit_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(img_o) |-> $past(commit_v));
  assert_ctrl_q0_only_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_o) |-> $past(commit_v && commit_q[0]));
  assert_onehot_select_R5: assert property (@(posedge clk) disable iff (rst)
    commit_v |-> ($countones(commit_q) == 1));
endmodule

// File: rtl/lcd_serial_rx.sv
module lcd_serial_rx
  import lcdrx_pkg::*;
#(
  parameter logic [ADDR_BITS-1:0] DEV_ADDR = 8'h46,
  parameter int IMG_BITS = 136,
  parameter int QBITS    = 36,
  parameter int NQ       = 4,
  parameter int MIN_CYC  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_ce,
  input  logic                ser_clk,
  input  logic                ser_din,
  input  logic                inhibit_n,
  output logic [IMG_BITS-1:0] disp_image,
  output logic [3:0]          port_sel,
  output logic                bias_half,
  output logic                seg_blank,
  output logic                pwr_save,
  output logic                force_off
);
  localparam int DATA_W = QBITS + CTRL_BITS - 1;
  localparam int I_CE = 0, I_CK = 1, I_DI = 2;

  logic [2:0]        lvl, rise, fall;
  logic              viol, commit_v;
  logic [NQ-1:0]     commit_q;
  logic [DATA_W-1:0] commit_data;
  ctrl_t             ctrl;
  logic              inh_m, inh_s;

  lcdrx_sync #(.W(3)) sync_i (
    .clk(clk), .rst(rst),
    .async_in({ser_din, ser_clk, ser_ce}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  lcdrx_guard #(.MIN_CYC(MIN_CYC)) guard_i (
    .clk(clk), .rst(rst),
    .ce_lvl(lvl[I_CE]), .ce_rise(rise[I_CE]),
    .sclk_rise(rise[I_CK]), .sclk_fall(fall[I_CK]),
    .din_chg(rise[I_DI] | fall[I_DI]),
    .viol(viol)
  );

  lcdrx_shifter #(.DEV_ADDR(DEV_ADDR), .QBITS(QBITS), .NQ(NQ)) shift_i (
    .clk(clk), .rst(rst),
    .ce_lvl(lvl[I_CE]), .ce_rise(rise[I_CE]), .ce_fall(fall[I_CE]),
    .sclk_rise(rise[I_CK]), .din_lvl(lvl[I_DI]), .viol(viol),
    .commit_v(commit_v), .commit_q(commit_q), .commit_data(commit_data)
  );

  lcdrx_store #(.IMG_BITS(IMG_BITS), .QBITS(QBITS), .NQ(NQ)) store_i (
    .clk(clk), .rst(rst),
    .commit_v(commit_v), .commit_q(commit_q), .commit_data(commit_data),
    .img_o(disp_image), .ctrl_o(ctrl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      inh_m     <= 1'b0;
      inh_s     <= 1'b0;
      force_off <= 1'b1;
    end else begin
      inh_m     <= inhibit_n;
      inh_s     <= inh_m;
      force_off <= ~inh_s;
    end
  end

  assign port_sel  = ctrl.port_sel;
  assign bias_half = ctrl.bias_half;
  assign seg_blank = ctrl.blank;
  assign pwr_save  = ctrl.pwr_save;

  assert_force_off_R10: assert property (@(posedge clk) disable iff (rst)
    !inh_s |=> force_off);
endmodule

// File: tb/lcd_serial_rx_tb_top.sv
module lcd_serial_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int GAP  = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_ce = 1'b0, ser_clk = 1'b0, ser_din = 1'b0, inhibit_n = 1'b0;
  logic [135:0] disp_image;
  logic [3:0]   port_sel;
  logic bias_half, seg_blank, pwr_save, force_off;

  logic [135:0] exp_img = '0;
  logic [3:0]   exp_port = '0;
  logic exp_bias = 1'b0, exp_blank = 1'b0, exp_ps = 1'b0;
  bit idle_hi = 1'b0;
  bit done = 1'b0;
  int checks = 0, fails = 0;

  lcd_serial_rx dut_i (
    .clk(clk), .rst(rst), .ser_ce(ser_ce), .ser_clk(ser_clk), .ser_din(ser_din),
    .inhibit_n(inhibit_n), .disp_image(disp_image), .port_sel(port_sel),
    .bias_half(bias_half), .seg_blank(seg_blank), .pwr_save(pwr_save),
    .force_off(force_off)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(string req);
    checks++;
    if (disp_image !== exp_img ||
        {port_sel, bias_half, seg_blank, pwr_save} !== {exp_port, exp_bias, exp_blank, exp_ps}) begin
      fails++;
      $display("FAIL %s image act=%h exp=%h ctrl act=%b exp=%b", req, disp_image, exp_img,
               {port_sel, bias_half, seg_blank, pwr_save}, {exp_port, exp_bias, exp_blank, exp_ps});
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mkframe(int q, logic [35:0] d, logic [7:0] c);
    logic [3:0] dir = '0;
    dir[q] = 1'b1;
    return {dir, c, d};
  endfunction

  task automatic apply(logic [47:0] fr);
    int q = 0;
    for (int k = 0; k < 4; k++) if (fr[44+k]) q = k;
    for (int i = 0; i < 36; i++) if (q*36 + i < 136) exp_img[q*36 + i] = fr[i];
    if (q == 0) begin
      exp_port = fr[39:36]; exp_bias = fr[40]; exp_blank = fr[41]; exp_ps = fr[42];
    end
  endtask

  task automatic send_bit(logic b, bit short_hi);
    if (idle_hi) begin
      ser_clk = 1'b0; ser_din = b; tick(HALF);
      ser_clk = 1'b1; tick(short_hi ? 2 : HALF);
    end else begin
      ser_din = b; tick(HALF);
      ser_clk = 1'b1; tick(short_hi ? 2 : HALF);
      ser_clk = 1'b0;
    end
  endtask

  task automatic xfer(logic [15:0] addr, int abits, logic [63:0] fr, int fbits,
                      int short_at, bit hold_check);
    tick(GAP);
    for (int i = 0; i < abits; i++) send_bit(addr[i], 1'b0);
    tick(GAP); ser_ce = 1'b1; tick(GAP);
    for (int i = 0; i < fbits; i++) send_bit(fr[i], i == short_at);
    tick(GAP);
    if (hold_check) check_state("R7 outputs held while chip enable high");
    ser_ce = 1'b0; tick(GAP);
  endtask

  task automatic t_reset;
    check_state("R10 reset image/control zero");
    check_bit("R10 force_off after reset", force_off, 1'b1);
    inhibit_n = 1'b1; tick(6);
    check_bit("R10 force_off released", force_off, 1'b0);
  endtask

  task automatic t_quarter0;
    logic [47:0] fr = mkframe(0, 36'h9_A5C3_1E7F, 8'h5A);
    xfer(16'h46, 8, {16'h0, fr}, 48, -1, 1'b1);
    apply(fr);
    check_state("R3 R6 quarter 0 with control");
  endtask

  task automatic t_quarter1_padding;
    logic [47:0] fr = mkframe(1, 36'h3_0F0F_55AA, 8'h35);
    xfer(16'h46, 8, {16'h0, fr}, 48, -1, 1'b0);
    apply(fr);
    check_state("R6 R11 quarter 1 leaves control");
  endtask

  task automatic t_bad_addr;
    xfer(16'h47, 8, {16'h0, mkframe(2, 36'hF_FFFF_FFFF, 8'h00)}, 48, -1, 1'b0);
    check_state("R1 wrong address ignored");
  endtask

  task automatic t_addr_len;
    xfer(16'h08C, 9, {16'h0, mkframe(2, 36'hF_FFFF_FFFF, 8'h00)}, 48, -1, 1'b0);
    check_state("R2 nine address bits rejected");
    xfer(16'h46, 7, {16'h0, mkframe(2, 36'hF_FFFF_FFFF, 8'h00)}, 48, -1, 1'b0);
    check_state("R2 seven address bits rejected");
  endtask

  task automatic t_frame_len;
    xfer(16'h46, 8, {16'h0, mkframe(0, 36'h1_2345_6789, 8'h07)}, 47, -1, 1'b0);
    check_state("R4 47-bit frame discarded");
    xfer(16'h46, 8, {15'h0, 1'b1, mkframe(0, 36'h1_2345_6789, 8'h07)}, 49, -1, 1'b0);
    check_state("R4 49-bit frame discarded");
  endtask

  task automatic t_bad_dir;
    xfer(16'h46, 8, {16'h0, 4'b0011, 8'h00, 36'hA_AAAA_AAAA}, 48, -1, 1'b0);
    check_state("R5 two direction bits discarded");
    xfer(16'h46, 8, {16'h0, mkframe(0, 36'hA_AAAA_AAAA, 8'h80)}, 48, -1, 1'b0);
    check_state("R5 reserved bit set discarded");
  endtask

  task automatic t_timing;
    xfer(16'h46, 8, {16'h0, mkframe(2, 36'h6_DB6D_B6DB, 8'h00)}, 48, 10, 1'b0);
    check_state("R9 short clock pulse discards frame");
  endtask

  task automatic t_idle_high;
    logic [47:0] f2 = mkframe(2, 36'hC_3C3C_3C3C, 8'h00);
    logic [47:0] f3 = mkframe(3, 36'hF_FFFF_FFFF, 8'h00);
    logic [47:0] f0 = mkframe(0, 36'h0_1248_8421, 8'h23);
    ser_clk = 1'b1; tick(GAP);
    ser_ce = 1'b1; tick(GAP); ser_ce = 1'b0; tick(GAP);
    check_state("R4 empty frame while switching idle level");
    idle_hi = 1'b1;
    xfer(16'h46, 8, {16'h0, f2}, 48, -1, 1'b0);
    apply(f2);
    check_state("R8 R11 quarter 2 with clock resting high");
    xfer(16'h46, 8, {16'h0, f3}, 48, -1, 1'b0);
    apply(f3);
    check_state("R11 quarter 3 upper frame bits dropped");
    xfer(16'h46, 8, {16'h0, f0}, 48, -1, 1'b0);
    apply(f0);
    check_state("R8 R6 quarter 0 control with clock resting high");
  endtask

  task automatic t_inhibit;
    logic [47:0] fr = mkframe(1, 36'h5_5555_0000, 8'h00);
    inhibit_n = 1'b0; tick(6);
    check_bit("R10 force_off on inhibit", force_off, 1'b1);
    xfer(16'h46, 8, {16'h0, fr}, 48, -1, 1'b0);
    apply(fr);
    check_state("R10 frame accepted while inhibited");
  endtask

  initial begin
    tick(4); rst = 1'b0; tick(4);
    t_reset;
    t_quarter0;
    t_quarter1_padding;
    t_bad_addr;
    t_addr_len;
    t_frame_len;
    t_bad_dir;
    t_timing;
    t_idle_high;
    t_inhibit;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog all requirements act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule